// File: doc/BRIEF.md
# Banked Register Front End for an Eight-Channel Light Pulse Generator

This block is the byte-wide register front end of an eight-channel light pulse generator. A host issues single-byte read and write accesses. Every channel owns seven control bytes, but they all share one small address window: a channel-select register decides which channel a control access reaches. A separate run mask holds one run bit per channel. A two-register port fills a shared duty lookup table of 9-bit entries. A test register routes the output of one channel onto a debug line.

Control bytes are kept in two layers per channel. Writes and reads touch a staging copy. The live copy feeds the channel's PWM and ramp logic, and it takes the whole staged set only when control byte 0 is written. Byte 0 carries the start bits, so software writes it last. A one-cycle launch pulse marks that moment for the channel.

Accesses enter on a valid/ready channel: `acc_valid` with `acc_write`, `acc_addr` and `acc_wdata` is taken on a clock edge where `acc_ready` is high. A read returns its byte on a valid/ready response channel one cycle after acceptance. While a response is waiting and `rsp_ready` is low, `rsp_data` is held and `acc_ready` is low, so no access is taken. A write produces no response.

Top module: `lpg_reg_frontend`

## Requirements
- R1: A write to address 0x13C+k (k = 0..6) stores the byte as control byte k of the channel held in the select register. A read of the same address returns that channel's stored byte k.
- R2: The select register at 0x143 keeps the channel number in bits 2:0. A control write changes only the selected channel, and a read of 0x143 returns the number in bits 2:0 with the upper bits zero.
- R3: The live bytes of a channel on `ch_ctl_o` change only when its control byte 0 is written. That write copies all seven staged bytes at once, and `ch_launch_o` bit n is high for exactly the following cycle.
- R4: The run register at 0x144 drives `ch_run_o`, with bit n as the run bit of channel n, and reads back unchanged.
- R5: A table entry is written in two steps. First the data bits 7:0 are written to 0x145. Then a write to 0x146 with bit 6 clear commits entry {bit 7, held low byte} at the index in bits 5:0. A write to 0x145 alone changes no entry. `tbl_data_o` shows the entry at `tbl_idx_i` combinationally.
- R6: A write to 0x146 with bit 6 set changes no entry. It captures the entry at the index in bits 5:0. Afterwards 0x145 reads its bits 7:0, and 0x146 reads its bit 8 in bit 7 with all other bits zero.
- R7: The test register at 0x147 holds a channel in bits 2:0 and a line select in bits 5:3. With select value 1, `dbg_o` follows `ch_out_i` of that channel. Any other select value holds `dbg_o` low.
- R8: Addresses outside 0x13C..0x147 read as zero, and writes to them change no state.
- R9: Reset clears every staged and live byte, the select, run and test registers, and every table entry.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `acc_ready` is low and `rsp_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted on this edge when high |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | Byte address |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 8 | Read data |
| ch_ctl_o | output | 448 | Live control bytes; channel c byte b at bits [(c*7+b)*8 +: 8] |
| ch_launch_o | output | 8 | One-cycle pulse per channel after its byte 0 write |
| ch_run_o | output | 8 | Run mask, bit n for channel n |
| tbl_idx_i | input | 6 | Lookup index from the ramp logic |
| tbl_data_o | output | 9 | Table entry at tbl_idx_i |
| ch_out_i | input | 8 | PWM output of each channel |
| dbg_o | output | 1 | Test line 1 |

## Verification
The bench fills bytes 1 to 6 of one channel and checks that the live outputs stay at zero until byte 0 arrives. A design that passes control writes straight through would leak a half-updated setup to the PWM logic at that point. It then switches the channel select between two channels and reads back from both. A design that drops the select would overwrite one bank from the other. On the table it writes a low byte without a commit and sends a read request with bit 6 set. A design that commits on the low byte, or that treats the read request as a write, changes an entry there. Last, it holds `rsp_ready` low with a response pending. A front end that keeps accepting accesses in that state would overwrite the pending response.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int LPG_DW       = 8;
  localparam int LPG_ENTRY_W  = 9;
  localparam int THI_BIT8     = 7;
  localparam int THI_RDREQ    = 6;
  localparam int TST_CH_W     = 3;
  localparam int TST_SEL_W    = 3;
  localparam int TST_LINE1    = 1;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTL,
    RG_SEL,
    RG_RUN,
    RG_TLO,
    RG_THI,
    RG_TEST
  } lpg_region_e;
endpackage

// File: rtl/lpg_bank_store.sv
module lpg_bank_store #(
  parameter int NUM_CH    = 8,
  parameter int CTL_BYTES = 7,
  parameter int BANK_W    = $clog2(NUM_CH),
  parameter int OFF_W     = $clog2(CTL_BYTES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic [BANK_W-1:0]               bank_i,
  input  logic [OFF_W-1:0]                off_i,
  input  logic [7:0]                      wdata_i,
  output logic [7:0]                      stg_rd_o,
  output logic [NUM_CH-1:0][CTL_BYTES-1:0][7:0] live_o,
  output logic [NUM_CH-1:0]               launch_o
);
  logic [NUM_CH-1:0][CTL_BYTES-1:0][7:0] stage_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_ch;
    assign hit_ch = wr_i && (bank_i == BANK_W'(c));

    for (genvar b = 0; b < CTL_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           stage_q[c][b] <= '0;
        else if (hit_ch && off_i == OFF_W'(b)) stage_q[c][b] <= wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_o[c]   <= '0;
        launch_o[c] <= 1'b0;
      end else begin
        launch_o[c] <= hit_ch && (off_i == '0);
        if (hit_ch && off_i == '0)
          live_o[c] <= {stage_q[c][CTL_BYTES-1:1], wdata_i};
      end
    end

    AST_LIVE_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_o[c] |-> $stable(live_o[c])); // R3
  end

  always_comb begin
    stg_rd_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int b = 0; b < CTL_BYTES; b++)
        if (bank_i == BANK_W'(c) && off_i == OFF_W'(b))
          stg_rd_o = stage_q[c][b];
  end
endmodule

// File: rtl/lpg_duty_table.sv
module lpg_duty_table
  import lpg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lo_we_i,
  input  logic                   hi_we_i,
  input  logic [7:0]             wdata_i,
  input  logic [IDX_W-1:0]       look_idx_i,
  output logic [LPG_ENTRY_W-1:0] look_data_o,
  output logic [LPG_ENTRY_W-1:0] cap_o
);
  logic [DEPTH-1:0][LPG_ENTRY_W-1:0] mem_q;
  logic [7:0]                        pend_lo_q;
  logic [IDX_W-1:0]                  hi_idx;
  logic                              rd_req;

  assign hi_idx = wdata_i[IDX_W-1:0];
  assign rd_req = wdata_i[THI_RDREQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_lo_q <= '0;
    else if (lo_we_i) pend_lo_q <= wdata_i;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[e] <= '0;
      else if (hi_we_i && !rd_req && hi_idx == IDX_W'(e))
        mem_q[e] <= {wdata_i[THI_BIT8], pend_lo_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cap_o <= '0;
    else if (hi_we_i && rd_req) cap_o <= mem_q[hi_idx];
  end

  assign look_data_o = mem_q[look_idx_i];

  AST_LO_ALONE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we_i |=> $stable(mem_q)); // R5
  AST_RDREQ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_i && rd_req) |=> $stable(mem_q)); // R6
  AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_i && !rd_req) |=> mem_q[$past(hi_idx)] == {$past(wdata_i[THI_BIT8]), $past(pend_lo_q)}); // R5
endmodule

// File: rtl/lpg_test_route.sv
module lpg_test_route
  import lpg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TST_W  = TST_CH_W + TST_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [TST_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] ch_out_i,
  output logic [TST_W-1:0]  reg_o,
  output logic              dbg_o
);
  logic [TST_CH_W-1:0]  chan;
  logic [TST_SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reg_o <= '0;
    else if (we_i) reg_o <= wdata_i;
  end

  assign chan = reg_o[TST_CH_W-1:0];
  assign sel  = reg_o[TST_W-1:TST_CH_W];

  always_comb begin
    dbg_o = 1'b0;
    if (sel == TST_SEL_W'(TST_LINE1))
      for (int c = 0; c < NUM_CH; c++)
        if (chan == TST_CH_W'(c)) dbg_o = ch_out_i[c];
  end
endmodule

// File: rtl/lpg_reg_frontend.sv
module lpg_reg_frontend
  import lpg_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int CTL_BYTES = 7,
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 'h13C,
  parameter int TBL_DEPTH = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc_valid,
  output logic                            acc_ready,
  input  logic                            acc_write,
  input  logic [ADDR_W-1:0]               acc_addr,
  input  logic [LPG_DW-1:0]               acc_wdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [LPG_DW-1:0]               rsp_data,
  output logic [NUM_CH*CTL_BYTES*8-1:0]   ch_ctl_o,
  output logic [NUM_CH-1:0]               ch_launch_o,
  output logic [NUM_CH-1:0]               ch_run_o,
  input  logic [$clog2(TBL_DEPTH)-1:0]    tbl_idx_i,
  output logic [LPG_ENTRY_W-1:0]          tbl_data_o,
  input  logic [NUM_CH-1:0]               ch_out_i,
  output logic                            dbg_o
);
  localparam int BANK_W = $clog2(NUM_CH);
  localparam int OFF_W  = $clog2(CTL_BYTES);
  localparam int IDX_W  = $clog2(TBL_DEPTH);
  localparam int TST_W  = TST_CH_W + TST_SEL_W;

  lpg_region_e       region;
  logic [ADDR_W-1:0] rel;
  logic              fire, wr, rd;
  logic [BANK_W-1:0] sel_q;
  logic [LPG_DW-1:0] stg_rd, rd_mux;
  logic [LPG_ENTRY_W-1:0] cap;
  logic [TST_W-1:0]  tst_reg;
  logic [NUM_CH-1:0][CTL_BYTES-1:0][7:0] live;

  // address decode
  assign rel = acc_addr - ADDR_W'(BASE_ADDR);
  always_comb begin
    region = RG_NONE;
    if (acc_addr >= ADDR_W'(BASE_ADDR)) begin
      if (rel < ADDR_W'(CTL_BYTES))            region = RG_CTL;
      else if (rel == ADDR_W'(CTL_BYTES))      region = RG_SEL;
      else if (rel == ADDR_W'(CTL_BYTES + 1))  region = RG_RUN;
      else if (rel == ADDR_W'(CTL_BYTES + 2))  region = RG_TLO;
      else if (rel == ADDR_W'(CTL_BYTES + 3))  region = RG_THI;
      else if (rel == ADDR_W'(CTL_BYTES + 4))  region = RG_TEST;
    end
  end

  // access handshake
  assign acc_ready = !rsp_valid || rsp_ready;
  assign fire      = acc_valid && acc_ready;
  assign wr        = fire && acc_write;
  assign rd        = fire && !acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ch_run_o <= '0;
    end else if (wr) begin
      if (region == RG_SEL) sel_q    <= acc_wdata[BANK_W-1:0];
      if (region == RG_RUN) ch_run_o <= acc_wdata[NUM_CH-1:0];
    end
  end

  lpg_bank_store #(.NUM_CH(NUM_CH), .CTL_BYTES(CTL_BYTES)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr && region == RG_CTL),
    .bank_i   (sel_q),
    .off_i    (rel[OFF_W-1:0]),
    .wdata_i  (acc_wdata),
    .stg_rd_o (stg_rd),
    .live_o   (live),
    .launch_o (ch_launch_o)
  );
  assign ch_ctl_o = live;

  lpg_duty_table #(.DEPTH(TBL_DEPTH)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_we_i     (wr && region == RG_TLO),
    .hi_we_i     (wr && region == RG_THI),
    .wdata_i     (acc_wdata),
    .look_idx_i  (tbl_idx_i),
    .look_data_o (tbl_data_o),
    .cap_o       (cap)
  );

  lpg_test_route #(.NUM_CH(NUM_CH)) u_test (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (wr && region == RG_TEST),
    .wdata_i  (acc_wdata[TST_W-1:0]),
    .ch_out_i (ch_out_i),
    .reg_o    (tst_reg),
    .dbg_o    (dbg_o)
  );

  // read mux
  always_comb begin
    unique case (region)
      RG_CTL:  rd_mux = stg_rd;
      RG_SEL:  rd_mux = LPG_DW'(sel_q);
      RG_RUN:  rd_mux = LPG_DW'(ch_run_o);
      RG_TLO:  rd_mux = cap[7:0];
      RG_THI:  rd_mux = {cap[8], 7'b0};
      RG_TEST: rd_mux = LPG_DW'(tst_reg);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_launch_o)); // R2
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == RG_NONE) |=> ($stable(sel_q) && $stable(ch_run_o) && $stable(ch_ctl_o) && $stable(tst_reg))); // R8
endmodule

// File: tb/lpg_reg_frontend_bench.sv
module lpg_reg_frontend_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, rsp_ready = 1'b1;
  logic [9:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic acc_ready, rsp_valid, dbg_o;
  logic [7:0] rsp_data, ch_launch_o, ch_run_o;
  logic [7:0] ch_out_i = '0;
  logic [5:0] tbl_idx_i = '0;
  logic [8:0] tbl_data_o;
  logic [447:0] ch_ctl_o;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpg_reg_frontend u_lpg_reg_frontend (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ch_ctl_o(ch_ctl_o), .ch_launch_o(ch_launch_o), .ch_run_o(ch_run_o),
    .tbl_idx_i(tbl_idx_i), .tbl_data_o(tbl_data_o), .ch_out_i(ch_out_i), .dbg_o(dbg_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] live_byte(input int c, input int b);
    return ch_ctl_o[(c*7+b)*8 +: 8];
  endfunction

  task automatic acc(input logic w, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, a, 8'h00);
  endtask

  task automatic look(input logic [5:0] idx, input logic [8:0] exp, input string tag);
    @(negedge clk);
    tbl_idx_i = idx;
    #1 chk(tag, 16'(tbl_data_o), 16'(exp));
  endtask

  // monitor: pops expected reads as responses are handed over
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected response act=%h exp=none", rsp_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_data !== e) begin
          failures++;
          $display("FAIL %s act=%h exp=%h", t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 run mask", 16'(ch_run_o), 16'h0);
    chk("R9 live byte", 16'(live_byte(0, 0)), 16'h0);
    look(6'd5, 9'h0, "R9 table entry");
    rd(10'h143, 8'h00, "R9 select readback");
    rd(10'h13C, 8'h00, "R9 ctl readback");

    // R1/R3 staged writes to channel 2
    wr(10'h143, 8'hFA);          // upper bits dropped -> 2
    rd(10'h143, 8'h02, "R2 select keeps bits 2:0");
    for (int b = 1; b < 7; b++) wr(10'(10'h13C + b), 8'(8'h10 + b));
    chk("R3 live unchanged before byte0", 16'(live_byte(2, 1)), 16'h0);
    rd(10'h13E, 8'h12, "R1 staged readback");
    wr(10'h13C, 8'h0C);
    chk("R3 launch pulse", 16'(ch_launch_o), 16'h04);
    for (int b = 0; b < 7; b++)
      chk("R3 live after byte0", 16'(live_byte(2, b)), 16'(b == 0 ? 8'h0C : 8'(8'h10 + b)));
    chk("R2 other bank untouched", 16'(live_byte(0, 1)), 16'h0);
    @(negedge clk);
    chk("R3 launch one cycle", 16'(ch_launch_o), 16'h0);

    // R2 bank switching
    wr(10'h143, 8'h05);
    wr(10'h13E, 8'h77);
    rd(10'h13E, 8'h77, "R1 bank5 readback");
    chk("R3 bank5 not launched", 16'(live_byte(5, 2)), 16'h0);
    wr(10'h143, 8'h02);
    rd(10'h13E, 8'h12, "R2 bank2 kept");

    // R4 run mask
    wr(10'h144, 8'hA5);
    chk("R4 run mask", 16'(ch_run_o), 16'hA5);
    rd(10'h144, 8'hA5, "R4 run readback");

    // R5 table write
    wr(10'h145, 8'h3C);
    look(6'd9, 9'h000, "R5 low byte alone");
    wr(10'h146, 8'h89);
    look(6'd9, 9'h13C, "R5 committed entry");
    wr(10'h145, 8'hFF);
    look(6'd9, 9'h13C, "R5 no commit on low write");
    look(6'd10, 9'h000, "R5 neighbour untouched");

    // R6 table read request
    wr(10'h146, 8'h49);
    look(6'd9, 9'h13C, "R6 read request no write");
    rd(10'h145, 8'h3C, "R6 captured low");
    rd(10'h146, 8'h80, "R6 captured bit8");

    // R7 test routing
    wr(10'h147, 8'h0B);
    @(negedge clk); ch_out_i = 8'h08;
    #1 chk("R7 routed high", 16'(dbg_o), 16'h1);
    @(negedge clk); ch_out_i = 8'hF7;
    #1 chk("R7 routed low", 16'(dbg_o), 16'h0);
    wr(10'h147, 8'h13);
    @(negedge clk); ch_out_i = 8'h08;
    #1 chk("R7 other select quiet", 16'(dbg_o), 16'h0);
    rd(10'h147, 8'h13, "R7 test readback");

    // R8 unmapped
    wr(10'h150, 8'hFF);
    wr(10'h13B, 8'hFF);
    rd(10'h150, 8'h00, "R8 unmapped high");
    rd(10'h13B, 8'h00, "R8 unmapped low");
    chk("R8 run unchanged", 16'(ch_run_o), 16'hA5);
    rd(10'h143, 8'h02, "R8 select unchanged");

    // R10 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(10'h144, 8'hA5, "R10 held response");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R10 ready low", 16'(acc_ready), 16'h0);
      chk("R10 data held", 16'({rsp_valid, rsp_data}), 16'h1A5);
    end
    @(negedge clk); rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 queue drained", 16'(exp_q.size()), 16'h0);

    // R9 reset clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 run cleared", 16'(ch_run_o), 16'h0);
    chk("R9 live cleared", 16'(live_byte(2, 0)), 16'h0);
    look(6'd9, 9'h000, "R9 table cleared");
    rd(10'h13E, 8'h00, "R9 stage cleared");
    repeat (4) @(negedge clk);
    chk("R9 queue drained", 16'(exp_q.size()), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule